// File: doc/BRIEF.md
# Message-to-Flit Packetizer

This block sits at the injection point of one network node. It takes in a complete message in one handshake: destination, source, message number, scheduled injection step and up to `MAX_WORDS` data words. It turns the message into a wormhole flit stream on a valid/ready output. The stream has a routing header, then a flit that carries the data-word count, then the data words in order.

The message is held until a free-running global step counter, supplied from outside, equals the message's scheduled step. Only then is the header offered. Once the header has been offered, the rest of the packet follows without regard to the step counter, and nothing else is accepted until the packet has left. Each flit carries a countdown index and a last-flit marker.

Top module: `flit_packetizer`

## Requirements
- R1: The first flit of a packet is the header. Bits [ID_W-1:0] hold the message number, the next ADDR_W bits hold the source and the ADDR_W bits above them hold the destination. All higher bits are zero.
- R2: The second flit holds the data-word count in bits [CNT_W-1:0], zero above.
- R3: Data word k of the message (`msg_data[k*FLIT_W +: FLIT_W]`, k from 0 to count-1) leaves as flit k+2, in increasing k.
- R4: A message with n data words produces exactly n+2 flits. `flit_idx` runs from n+1 on the header down to 0 on the final flit, one step per accepted flit.
- R5: While `flit_valid` is high, `flit_last` is high exactly when `flit_idx` is 0.
- R6: A held message is not offered, and `flit_valid` stays low, until `step` equals the message's scheduled step.
- R7: Once the header has been offered, the remaining flits are offered whatever the value of `step`.
- R8: While `flit_valid` is high and `flit_ready` is low, the valid signal, data, index and last flag hold their values into the next cycle.
- R9: `msg_ready` is low from the cycle after a message is taken until the final flit is accepted, so packets never interleave. It is high again in the cycle after that final handshake.
- R10: After reset, `flit_valid` is low and `msg_ready` is high.
- R11: A message with zero data words produces only the header and the count flit, and the count flit carries index 0 and the last flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | STEP_W | Global step counter |
| msg_valid | input | 1 | Message offered |
| msg_ready | output | 1 | Block can take a message |
| msg_dest | input | ADDR_W | Destination node |
| msg_src | input | ADDR_W | Source node |
| msg_id | input | ID_W | Message number |
| msg_time | input | STEP_W | Scheduled injection step |
| msg_count | input | CNT_W | Number of data words (at most MAX_WORDS) |
| msg_data | input | MAX_WORDS*FLIT_W | Data words, word k at bits k*FLIT_W upward |
| flit_valid | output | 1 | Flit offered |
| flit_ready | input | 1 | Downstream takes the flit |
| flit_data | output | FLIT_W | Flit contents |
| flit_last | output | 1 | Final flit of the packet |
| flit_idx | output | IDX_W | Countdown index of the flit |

## Verification
A message is taken at the clock edge where `msg_valid` and `msg_ready` are both high. The header can appear combinationally in any later cycle in which `step` matches the stored step. Each following flit is due in the cycle after the previous one was accepted, and `msg_ready` returns in the cycle after the final handshake. The bench drives `step` and `flit_ready` just after each falling edge and samples one time unit later, before the next rising edge. It keeps a per-message flit pointer that advances only when it saw valid and ready together in that cycle, so every expected flit is compared in exactly the cycle it is due. The sweep covers all data counts from 0 to 6, three ready patterns including a stall on the header, and two injection delays.

// File: rtl/flit_packetizer.sv
module flit_packetizer #(
  parameter int ADDR_W    = 4,
  parameter int ID_W      = 8,
  parameter int STEP_W    = 8,
  parameter int FLIT_W    = 16,
  parameter int MAX_WORDS = 6,
  localparam int CNT_W    = $clog2(MAX_WORDS + 1),
  localparam int IDX_W    = $clog2(MAX_WORDS + 2),
  localparam int HDR_W    = 2 * ADDR_W + ID_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [STEP_W-1:0]           step,
  input  logic                        msg_valid,
  output logic                        msg_ready,
  input  logic [ADDR_W-1:0]           msg_dest,
  input  logic [ADDR_W-1:0]           msg_src,
  input  logic [ID_W-1:0]             msg_id,
  input  logic [STEP_W-1:0]           msg_time,
  input  logic [CNT_W-1:0]            msg_count,
  input  logic [MAX_WORDS*FLIT_W-1:0] msg_data,
  output logic                        flit_valid,
  input  logic                        flit_ready,
  output logic [FLIT_W-1:0]           flit_data,
  output logic                        flit_last,
  output logic [IDX_W-1:0]            flit_idx
);

  logic                        busy, go;
  logic [IDX_W-1:0]            idx;
  logic [CNT_W-1:0]            cnt_q;
  logic [HDR_W-1:0]            hdr_q;
  logic [STEP_W-1:0]           time_q;
  logic [MAX_WORDS*FLIT_W-1:0] data_q;
  logic [IDX_W-1:0]            cnt_x, top_idx, word_sel;
  logic                        take;

  assign take      = msg_valid && !busy;
  assign msg_ready = !busy;
  assign cnt_x     = IDX_W'(cnt_q);
  assign top_idx   = cnt_x + IDX_W'(1);
  assign word_sel  = cnt_x - IDX_W'(1) - idx;

  assign flit_valid = busy && (go || step == time_q);
  assign flit_last  = flit_valid && idx == '0;
  assign flit_idx   = idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      go   <= 1'b0;
      idx  <= '0;
    end else if (!busy) begin
      if (msg_valid) begin
        busy <= 1'b1;
        go   <= 1'b0;
        idx  <= IDX_W'(msg_count) + IDX_W'(1);
      end
    end else begin
      if (flit_valid) go <= 1'b1;
      if (flit_valid && flit_ready) begin
        if (idx == '0) begin
          busy <= 1'b0;
          go   <= 1'b0;
        end else begin
          idx <= idx - IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      hdr_q  <= {msg_dest, msg_src, msg_id};
      cnt_q  <= msg_count;
      time_q <= msg_time;
      data_q <= msg_data;
    end
  end

  always_comb begin
    flit_data = '0;
    if (idx == top_idx) begin
      flit_data[HDR_W-1:0] = hdr_q;
    end else if (idx == cnt_x) begin
      flit_data[CNT_W-1:0] = cnt_q;
    end else begin
      for (int k = 0; k < MAX_WORDS; k++)
        if (word_sel == IDX_W'(k)) flit_data = data_q[k*FLIT_W +: FLIT_W];
    end
  end

endmodule

module flit_packetizer_chk #(
  parameter int FLIT_W = 16,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_ready,
  input logic              flit_valid,
  input logic              flit_ready,
  input logic [FLIT_W-1:0] flit_data,
  input logic              flit_last,
  input logic [IDX_W-1:0]  flit_idx
);

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid && !flit_ready |=> flit_valid && $stable(flit_data) &&
                                  $stable(flit_idx) && $stable(flit_last));

  a_r4_index_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid && flit_ready && !flit_last |=> flit_valid &&
                                  flit_idx == $past(flit_idx) - IDX_W'(1));

  a_r5_last_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid |-> (flit_last == (flit_idx == '0)));

  a_r9_no_interleave: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid |-> !msg_ready);

  a_r9_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid && flit_ready && flit_last |=> msg_ready && !flit_valid);

  a_r5_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    flit_last |-> flit_valid);

endmodule

bind flit_packetizer flit_packetizer_chk #(.FLIT_W(FLIT_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_ready(msg_ready), .flit_valid(flit_valid),
  .flit_ready(flit_ready), .flit_data(flit_data), .flit_last(flit_last),
  .flit_idx(flit_idx));

// File: tb/flit_packetizer_tb_top.sv
module flit_packetizer_tb_top;
  localparam int ADDR_W = 4, ID_W = 8, STEP_W = 8, FLIT_W = 16, MAX_WORDS = 6;
  localparam int CNT_W = $clog2(MAX_WORDS + 1);
  localparam int IDX_W = $clog2(MAX_WORDS + 2);

  logic clk = 0, rst_n = 0;
  logic [STEP_W-1:0] step = '0;
  logic msg_valid = 0, msg_ready;
  logic [ADDR_W-1:0] msg_dest = '0, msg_src = '0;
  logic [ID_W-1:0] msg_id = '0;
  logic [STEP_W-1:0] msg_time = '0;
  logic [CNT_W-1:0] msg_count = '0;
  logic [MAX_WORDS*FLIT_W-1:0] msg_data = '0;
  logic flit_valid, flit_ready = 0, flit_last;
  logic [FLIT_W-1:0] flit_data;
  logic [IDX_W-1:0] flit_idx;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  flit_packetizer #(.ADDR_W(ADDR_W), .ID_W(ID_W), .STEP_W(STEP_W),
                    .FLIT_W(FLIT_W), .MAX_WORDS(MAX_WORDS)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input bit rdy);
    @(negedge clk);
    step = step + 1'b1;
    flit_ready = rdy;
    #1;
  endtask

  function automatic logic [FLIT_W-1:0] word(input int seed, input int k);
    return FLIT_W'(seed * 37 + k * 1001 + 5);
  endfunction

  task automatic run_msg(input int n, input int delay, input int mode, input int seed);
    int e = 0, cyc = 0, total = n + 2;
    bit started = 0, rdy;
    logic [FLIT_W-1:0] exp_f;
    tick(0);
    chk(msg_ready == 1'b1, "R9 ready before message", 32'(msg_ready), 1);
    msg_dest  = ADDR_W'(seed + 3);
    msg_src   = ADDR_W'(seed * 5 + 1);
    msg_id    = ID_W'(seed);
    msg_count = CNT_W'(n);
    msg_time  = step + STEP_W'(delay);
    for (int k = 0; k < MAX_WORDS; k++) msg_data[k*FLIT_W +: FLIT_W] = word(seed, k);
    msg_valid = 1;
    while (e < total && cyc < 200) begin
      case (mode)
        0: rdy = 1;
        1: rdy = (cyc % 2) == 1;
        default: rdy = (cyc % 3) != 0;
      endcase
      tick(rdy);
      msg_valid = 0;
      cyc++;
      if (started || step == msg_time) begin
        chk(flit_valid == 1'b1, started ? "R7 continues after departure" : "R6 departs at step",
            32'(flit_valid), 1);
        chk(msg_ready == 1'b0, "R9 busy while sending", 32'(msg_ready), 0);
        if (e == 0) exp_f = FLIT_W'({msg_dest, msg_src, msg_id});
        else if (e == 1) exp_f = FLIT_W'(n);
        else exp_f = word(seed, e - 2);
        chk(flit_data == exp_f, e == 0 ? "R1 header" : (e == 1 ? "R2 count flit" : "R3 data word"),
            32'(flit_data), 32'(exp_f));
        chk(flit_idx == IDX_W'(total - 1 - e), "R4 flit index", 32'(flit_idx), 32'(total - 1 - e));
        chk(flit_last == (e == total - 1), n == 0 ? "R11 empty message last" : "R5 last flag",
            32'(flit_last), 32'(e == total - 1));
        started = 1;
        if (rdy) e++;
      end else begin
        chk(flit_valid == 1'b0, "R6 waits for step", 32'(flit_valid), 0);
      end
    end
    chk(e == total, "R4 flit total", 32'(e), 32'(total));
    tick(1);
    chk(flit_valid == 1'b0, "R9 idle after packet", 32'(flit_valid), 0);
    chk(msg_ready == 1'b1, "R9 ready after packet", 32'(msg_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(flit_valid == 1'b0, "R10 reset valid", 32'(flit_valid), 0);
    chk(msg_ready == 1'b1, "R10 reset ready", 32'(msg_ready), 1);
    rst_n = 1;
    for (int n = 0; n <= MAX_WORDS; n++)
      for (int mode = 0; mode < 3; mode++)
        for (int d = 0; d < 2; d++)
          run_msg(n, d == 0 ? 1 : 4, mode, n * 11 + mode * 3 + d + 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule